// File: doc/BRIEF.md
# Eight-Pin GPIO Controller with Edge Latching and Wake Routing

This block manages eight general-purpose pins for a serial-link modem front end. Software sets, one bit per pin, whether the pin is an output or an input, which level counts as active, whether an input is level-followed or edge-latched, and whether the pin may raise an event. For pins set as outputs, the block drives the value that arrived in the link's I/O control slot. A status register shows the live state of each pin. On edge-latched inputs it shows a held flag instead, which stays set until software clears it by writing a zero.

Every input passes through a two-flop synchronizer before its level or edge is evaluated. The enabled status bits are ORed into one event. While the link is up, the event goes out as the interrupt bit of the outgoing I/O control slot. While the link is down, it goes out on a separate wake line. Register reads are combinational. A register write takes effect at the clock edge on which `wr_en` is high.

Top module: `gpio_wake_ctrl`

## Requirements
- R1: After reset, the direction register reads 0x00FF, the polarity register reads 0xFFFF, and the capture-mode and event-enable registers read 0x0000. All `pin_oe` bits are 0. Register selects are: 0 direction, 1 polarity, 2 capture mode, 3 event enable, 4 status.
- R2: A direction bit of 0 makes the pin an output (`pin_oe` bit = 1). `pin_out` then carries the value captured from `slot_val` on the last cycle that `slot_vld` was high. A direction bit of 1 makes the pin an input.
- R3: For an input whose capture-mode bit is 0, the status bit reads 1 exactly when the synchronized pin equals its polarity bit. A polarity of 1 means active high and 0 means active low. The status bit follows the pin two clocks after the pin changes.
- R4: For an input whose capture-mode bit is 1 and polarity is 1, a rising edge sets the status bit. A falling edge does not set it.
- R5: For an input whose capture-mode bit is 1 and polarity is 0, a falling edge sets the status bit. A rising edge does not set it.
- R6: A set edge-latched status bit stays set after the pin returns to its idle level. Writing 0 to that bit of the status register clears it. Writing 1 to it has no effect.
- R7: If a clearing write to the status register and a new qualifying edge land on the same clock, the status bit stays set.
- R8: The combined event is the OR, over input pins, of status AND event-enable bit. With all enable bits at 0, no event is raised.
- R9: While `link_up` is 1, the combined event appears on `irq_slot` and `wake_req` stays 0. While `link_up` is 0, it appears on `wake_req` and `irq_slot` stays 0.
- R10: For an output pin, the status bit reports the value being driven on that pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for a write |
| wr_data | input | 8 | Write data, one bit per pin |
| rd_sel | input | 3 | Register select for a read |
| rd_data | output | 16 | Read data for `rd_sel` |
| slot_val | input | 8 | Output values from the I/O control slot |
| slot_vld | input | 1 | Capture strobe for `slot_val` |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |
| link_up | input | 1 | Serial link powered and active |
| irq_slot | output | 1 | Interrupt bit for the outgoing I/O control slot |
| wake_req | output | 1 | Wake request while the link is down |

## Verification
The bench checks that edge capture honours polarity in both directions. A design that ignored polarity would latch the wrong edge, or latch both edges. It checks that a written 1 leaves a latched flag in place and that a written 0 clears it. It also drives a clearing write on exactly the clock where a new edge lands: a design that lets the clear win would lose that edge. Finally, it checks that disabled pins raise nothing and that the event switches between the slot bit and the wake line as `link_up` changes. A wrong routing would either drive both outputs together or drop the event.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    typedef enum logic [2:0] {
        SEL_DIR  = 3'd0,
        SEL_POL  = 3'd1,
        SEL_MODE = 3'd2,
        SEL_EN   = 3'd3,
        SEL_STAT = 3'd4
    } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] sync_out
);
    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = async_in;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.s2;
endmodule

// File: rtl/gpio_edge.sv
module gpio_edge #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    input  logic [N-1:0] pol,
    output logic [N-1:0] evt
);
    logic [N-1:0] prev_d, prev_q;

    always_comb prev_d = lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_evt
        assign evt[i] = pol[i] ? (lvl[i] & ~prev_q[i]) : (~lvl[i] & prev_q[i]);
    end
endmodule

// File: rtl/gpio_wake_ctrl.sv
module gpio_wake_ctrl
    import gpio_pkg::*;
#(
    parameter int N  = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    wr_sel,
    input  logic [N-1:0]  wr_data,
    input  logic [2:0]    rd_sel,
    output logic [DW-1:0] rd_data,
    input  logic [N-1:0]  slot_val,
    input  logic          slot_vld,
    input  logic [N-1:0]  pin_in,
    output logic [N-1:0]  pin_out,
    output logic [N-1:0]  pin_oe,
    input  logic          link_up,
    output logic          irq_slot,
    output logic          wake_req
);
    localparam int PAD = DW - N;

    typedef struct packed {
        logic [N-1:0] dir;
        logic [N-1:0] pol;
        logic [N-1:0] mode;
        logic [N-1:0] en;
        logic [N-1:0] latch;
        logic [N-1:0] slot;
    } regs_t;

    regs_t r_d, r_q;

    logic [N-1:0] lvl_sync;
    logic [N-1:0] edge_evt;
    logic [N-1:0] status;
    logic         evt_any;
    logic         clr_wr;

    gpio_sync #(.N(N)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (lvl_sync)
    );

    gpio_edge #(.N(N)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (lvl_sync),
        .pol   (r_q.pol),
        .evt   (edge_evt)
    );

    assign clr_wr = wr_en && (reg_sel_e'(wr_sel) == SEL_STAT);

    always_comb begin
        r_d = r_q;
        if (slot_vld) r_d.slot = slot_val;
        if (wr_en) begin
            case (reg_sel_e'(wr_sel))
                SEL_DIR:  r_d.dir  = wr_data;
                SEL_POL:  r_d.pol  = wr_data;
                SEL_MODE: r_d.mode = wr_data;
                SEL_EN:   r_d.en   = wr_data;
                default:  ;
            endcase
        end
        for (int i = 0; i < N; i++) begin
            if (!(r_q.dir[i] && r_q.mode[i]))
                r_d.latch[i] = 1'b0;
            else if (edge_evt[i])
                r_d.latch[i] = 1'b1;
            else if (clr_wr && !wr_data[i])
                r_d.latch[i] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.dir   <= '1;
            r_q.pol   <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        for (int i = 0; i < N; i++) begin
            if (!r_q.dir[i])
                status[i] = r_q.slot[i];
            else if (r_q.mode[i])
                status[i] = r_q.latch[i];
            else
                status[i] = (lvl_sync[i] == r_q.pol[i]);
        end
    end

    assign evt_any  = |(status & r_q.en & r_q.dir);
    assign irq_slot = evt_any & link_up;
    assign wake_req = evt_any & ~link_up;
    assign pin_out  = r_q.slot;
    assign pin_oe   = ~r_q.dir;

    always_comb begin
        case (reg_sel_e'(rd_sel))
            SEL_DIR:  rd_data = {{PAD{1'b0}}, r_q.dir};
            SEL_POL:  rd_data = {{PAD{1'b1}}, r_q.pol};
            SEL_MODE: rd_data = {{PAD{1'b0}}, r_q.mode};
            SEL_EN:   rd_data = {{PAD{1'b0}}, r_q.en};
            SEL_STAT: rd_data = {{PAD{1'b0}}, status};
            default:  rd_data = '0;
        endcase
    end

    AST_ROUTE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(irq_slot && wake_req)); // R9
    AST_SLOT_NEEDS_LINK: assert property (@(posedge clk) disable iff (!rst_n) irq_slot |-> link_up); // R9
    AST_EVT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n) (irq_slot || wake_req) |-> (r_q.en != '0)); // R8

    for (genvar g = 0; g < N; g++) begin : g_ast
        AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (r_q.latch[g] && !wr_en) |=> r_q.latch[g]); // R6
        AST_LATCH_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(r_q.latch[g]) |-> $past(edge_evt[g])); // R4
    end
endmodule

// File: tb/sim_gpio_wake_ctrl.sv
module sim_gpio_wake_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [7:0]  wr_data = '0;
    logic [2:0]  rd_sel = '0;
    logic [15:0] rd_data;
    logic [7:0]  slot_val = '0;
    logic        slot_vld = 1'b0;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out;
    logic [7:0]  pin_oe;
    logic        link_up = 1'b0;
    logic        irq_slot;
    logic        wake_req;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    gpio_wake_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .slot_val(slot_val), .slot_vld(slot_vld),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .link_up(link_up),
        .irq_slot(irq_slot), .wake_req(wake_req)
    );

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] sel, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [2:0] sel, output logic [15:0] v);
        @(negedge clk);
        rd_sel = sel;
        #0.1 v = rd_data;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd(3'd0, v); check("R1 dir", v, 16'h00FF);
        rd(3'd1, v); check("R1 pol", v, 16'hFFFF);
        rd(3'd2, v); check("R1 mode", v, 16'h0000);
        rd(3'd3, v); check("R1 en", v, 16'h0000);
        check("R1 oe", {8'h0, pin_oe}, 16'h0000);
    endtask

    task automatic t_outputs();
        logic [15:0] v;
        @(negedge clk); slot_val = 8'hA5; slot_vld = 1'b1;
        @(negedge clk); slot_vld = 1'b0; slot_val = 8'h00;
        wr(3'd0, 8'hF0);
        check("R2 oe", {8'h0, pin_oe}, 16'h000F);
        check("R2 out", {12'h0, pin_out[3:0]}, 16'h0005);
        rd(3'd4, v); check("R10 status", v & 16'h000F, 16'h0005);
        wr(3'd0, 8'hFF);
        check("R2 oe back", {8'h0, pin_oe}, 16'h0000);
    endtask

    task automatic t_level();
        logic [15:0] v;
        @(negedge clk); pin_in[7] = 1'b1; settle();
        rd(3'd4, v); check("R3 high active", v & 16'h0080, 16'h0080);
        wr(3'd1, 8'h7F); settle();
        rd(3'd4, v); check("R3 low active pin high", v & 16'h0080, 16'h0000);
        @(negedge clk); pin_in[7] = 1'b0; settle();
        rd(3'd4, v); check("R3 low active pin low", v & 16'h0080, 16'h0080);
        wr(3'd1, 8'hFF); settle();
    endtask

    task automatic t_rise();
        logic [15:0] v;
        wr(3'd2, 8'h01);
        @(negedge clk); pin_in[0] = 1'b1; settle();
        rd(3'd4, v); check("R4 rise sets", v & 16'h0001, 16'h0001);
        wr(3'd4, 8'hFF);
        rd(3'd4, v); check("R6 write one no effect", v & 16'h0001, 16'h0001);
        wr(3'd4, 8'h00);
        rd(3'd4, v); check("R6 write zero clears", v & 16'h0001, 16'h0000);
        @(negedge clk); pin_in[0] = 1'b0; settle();
        rd(3'd4, v); check("R4 fall ignored", v & 16'h0001, 16'h0000);
        @(negedge clk); pin_in[0] = 1'b1; settle();
        @(negedge clk); pin_in[0] = 1'b0; settle();
        rd(3'd4, v); check("R6 held after idle", v & 16'h0001, 16'h0001);
        wr(3'd4, 8'h00);
    endtask

    task automatic t_fall();
        logic [15:0] v;
        wr(3'd2, 8'h03);
        wr(3'd1, 8'hFD);
        @(negedge clk); pin_in[1] = 1'b1; settle();
        rd(3'd4, v); check("R5 rise ignored", v & 16'h0002, 16'h0000);
        @(negedge clk); pin_in[1] = 1'b0; settle();
        rd(3'd4, v); check("R5 fall sets", v & 16'h0002, 16'h0002);
        wr(3'd4, 8'h00);
        wr(3'd1, 8'hFF);
    endtask

    task automatic t_race();
        logic [15:0] v;
        wr(3'd2, 8'h07);
        @(negedge clk); pin_in[2] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'd4; wr_data = 8'h00;
        @(negedge clk); wr_en = 1'b0;
        rd(3'd4, v); check("R7 edge beats clear", v & 16'h0004, 16'h0004);
    endtask

    task automatic t_irq();
        @(negedge clk); link_up = 1'b1;
        @(negedge clk);
        check("R8 no enable no event", {14'h0, irq_slot, wake_req}, 16'h0000);
        wr(3'd3, 8'h04);
        check("R9 link up slot bit", {14'h0, irq_slot, wake_req}, 16'h0002);
        @(negedge clk); link_up = 1'b0;
        @(negedge clk);
        check("R9 link down wake", {14'h0, irq_slot, wake_req}, 16'h0001);
        wr(3'd4, 8'h00);
        check("R8 cleared no event", {14'h0, irq_slot, wake_req}, 16'h0000);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_outputs();
                t_level();
                t_rise();
                t_fall();
                t_race();
                t_irq();
            end
            begin
                repeat (20000) @(posedge clk);
                n_tests++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule